// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block sits in the address stage of a load/store pipeline. It takes a decoded operand descriptor made of a mode code, a base register value, an index register value, a 16-bit constant and an operand size code. From these it produces the final memory address of the operand. Some modes also produce an updated base register value to be written back. The memory-indirect mode is different: it issues one read on a valid/ready memory port and uses the returned word as the address. Register and immediate operands do not touch memory. For these the block only raises a no-memory flag.

A command is accepted when `cmd_valid` and `cmd_ready` are both high at a clock edge. The controller has four states. IDLE is the only state that accepts a command. IDLE goes to DONE when the accepted command is any mode other than memory-indirect. IDLE goes to FETCH when the command is memory-indirect. FETCH holds the read request and goes to WAIT when the port accepts it. WAIT goes to DONE when `mem_rsp_valid` arrives. DONE presents the results for one cycle with `done` high, then returns to IDLE. The results appear on `ea`, `no_mem`, `wb_en` and `wb_val`. All results are latched at acceptance, except the indirect address, which is latched when the response arrives.

Top module: `ea_gen`

## Requirements
- R1: Mode code 2 (displacement) gives `ea` = base + disp, where disp is the 16-bit constant sign-extended to 32 bits. The sum wraps modulo 2^32.
- R2: Mode code 3 (register-indirect) gives `ea` = base. Mode code 4 (indexed) gives `ea` = base + index.
- R3: Mode code 5 (absolute) gives `ea` = the 16-bit constant zero-extended to 32 bits.
- R4: Mode code 6 (memory-indirect) issues exactly one read with `mem_req_addr` = base. The request and its address stay stable until `mem_req_ready` is seen. `done` rises only in the cycle after `mem_rsp_valid` is sampled. `ea` then equals `mem_rsp_data`.
- R5: Mode code 7 (post-increment) gives `ea` = base, `wb_en` = 1 and `wb_val` = base + operand size.
- R6: Mode code 8 (pre-decrement) gives `wb_val` = base − operand size, `ea` = `wb_val` and `wb_en` = 1. The subtraction wraps below zero.
- R7: Mode code 9 (scaled) gives `ea` = disp + base + index × operand size, with disp sign-extended.
- R8: Size code 0, 1, 2 and 3 select an operand size of 1, 2, 4 and 8 bytes.
- R9: Mode code 0 (register), mode code 1 (immediate) and the unused codes 10 to 15 set `no_mem` = 1 and `wb_en` = 0 at `done`. No mode except 6 ever raises `mem_req_valid`.
- R10: For every mode except 6, `done` is high for exactly one cycle, in the cycle right after acceptance. `cmd_ready` is low from acceptance until `done` has been shown. `wb_en` is high only together with `done`, and only for modes 7 and 8. `done` and `mem_req_valid` are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command (IDLE state) |
| cmd_mode | input | 4 | Addressing mode code |
| cmd_base | input | 32 | Base register value |
| cmd_index | input | 32 | Index register value |
| cmd_disp | input | 16 | Displacement or absolute constant |
| cmd_size | input | 2 | Operand size code (1, 2, 4 or 8 bytes) |
| mem_req_valid | output | 1 | Indirection read request |
| mem_req_ready | input | 1 | Memory port accepts the request |
| mem_req_addr | output | 32 | Indirection read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned pointer word |
| done | output | 1 | One-cycle pulse, results valid |
| ea | output | 32 | Effective address |
| no_mem | output | 1 | Operand needs no memory access |
| wb_en | output | 1 | Base register write-back enable |
| wb_val | output | 32 | Updated base register value |

## Verification
The hardest part to reach is the memory-indirect sequence under port back-pressure. In that case the request must be held with a stable address over several refused cycles, and `done` must not appear early while the response is still delayed. The bench's memory model takes a configurable number of refused cycles before it accepts a request, and a configurable response latency. Memory-indirect commands are run with several pairs of these settings, including zero stall with zero latency and long stall with long latency. Each returned word is a scrambled function of the request address, so an `ea` taken from the wrong address or in the wrong cycle does not match.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [3:0] {
        AM_REG     = 4'd0,
        AM_IMM     = 4'd1,
        AM_DISP    = 4'd2,
        AM_RIND    = 4'd3,
        AM_INDEX   = 4'd4,
        AM_ABS     = 4'd5,
        AM_MIND    = 4'd6,
        AM_POSTINC = 4'd7,
        AM_PREDEC  = 4'd8,
        AM_SCALED  = 4'd9
    } am_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } st_e;

endpackage

// File: rtl/ea_scale.sv
module ea_scale #(
    parameter int AW  = 32,
    parameter int SZW = 2
) (
    input  logic [SZW-1:0] size_code,
    input  logic [AW-1:0]  idx,
    output logic [AW-1:0]  step,
    output logic [AW-1:0]  scaled
);
    localparam int NSZ = 2 ** SZW;

    logic [AW-1:0] shifted [NSZ];
    logic [AW-1:0] steps   [NSZ];

    // one shifter tap per legal operand size
    for (genvar g = 0; g < NSZ; g++) begin : g_tap
        assign shifted[g] = idx << g;
        assign steps[g]   = AW'(1) << g;
    end

    assign scaled = shifted[size_code];
    assign step   = steps[size_code];

endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 16,
    parameter int SZW = 2
) (
    input  logic [3:0]     mode,
    input  logic [AW-1:0]  base,
    input  logic [AW-1:0]  index,
    input  logic [DW-1:0]  disp,
    input  logic [SZW-1:0] size_code,
    output logic [AW-1:0]  ea,
    output logic           nomem,
    output logic           wb_en,
    output logic [AW-1:0]  wb_val,
    output logic           indirect
);
    localparam int EXT = AW - DW;

    logic [AW-1:0] dsx;
    logic [AW-1:0] dzx;
    logic [AW-1:0] step;
    logic [AW-1:0] scaled_idx;
    logic [AW-1:0] dec_base;

    assign dsx      = {{EXT{disp[DW-1]}}, disp};
    assign dzx      = {{EXT{1'b0}}, disp};
    assign dec_base = base - step;

    ea_scale #(.AW(AW), .SZW(SZW)) u_scale (
        .size_code (size_code),
        .idx       (index),
        .step      (step),
        .scaled    (scaled_idx)
    );

    always_comb begin
        ea       = '0;
        nomem    = 1'b0;
        wb_en    = 1'b0;
        wb_val   = base;
        indirect = 1'b0;
        unique case (mode)
            AM_REG, AM_IMM: nomem = 1'b1;
            AM_DISP:        ea = base + dsx;
            AM_RIND:        ea = base;
            AM_INDEX:       ea = base + index;
            AM_ABS:         ea = dzx;
            AM_MIND: begin
                ea       = base;      // pointer fetch address
                indirect = 1'b1;
            end
            AM_POSTINC: begin
                ea     = base;
                wb_en  = 1'b1;
                wb_val = base + step;
            end
            AM_PREDEC: begin
                ea     = dec_base;
                wb_en  = 1'b1;
                wb_val = dec_base;
            end
            AM_SCALED:      ea = dsx + base + scaled_idx;
            default:        nomem = 1'b1;
        endcase
    end

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import ea_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [AW-1:0] calc_ea,
    input  logic          calc_nomem,
    input  logic          calc_wb_en,
    input  logic [AW-1:0] calc_wb_val,
    input  logic          calc_indirect,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [AW-1:0] mem_rsp_data,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic          no_mem,
    output logic          wb_en,
    output logic [AW-1:0] wb_val
);
    st_e state, state_nx;

    logic [AW-1:0] ea_q;
    logic          nomem_q;
    logic          wben_q;
    logic [AW-1:0] wbval_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cmd_valid) state_nx = calc_indirect ? ST_FETCH : ST_DONE;
            ST_FETCH: if (mem_req_ready) state_nx = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q    <= '0;
            nomem_q <= 1'b0;
            wben_q  <= 1'b0;
            wbval_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (cmd_valid) begin
                    ea_q    <= calc_ea;
                    nomem_q <= calc_nomem;
                    wben_q  <= calc_wb_en;
                    wbval_q <= calc_wb_val;
                end
                ST_WAIT: if (mem_rsp_valid) ea_q <= mem_rsp_data;
                default: ;
            endcase
        end
    end

    assign cmd_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_FETCH);
    assign mem_req_addr  = ea_q;
    assign done          = (state == ST_DONE);
    assign ea            = ea_q;
    assign no_mem        = done & nomem_q;
    assign wb_en         = done & wben_q;
    assign wb_val        = wbval_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R4
    AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !mem_rsp_valid) |=> !done); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done); // R10
    AST_NOMEM_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        no_mem |-> !wb_en); // R9

endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 16,
    parameter int SZW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    output logic           cmd_ready,
    input  logic [3:0]     cmd_mode,
    input  logic [AW-1:0]  cmd_base,
    input  logic [AW-1:0]  cmd_index,
    input  logic [DW-1:0]  cmd_disp,
    input  logic [SZW-1:0] cmd_size,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic [AW-1:0]  mem_req_addr,
    input  logic           mem_rsp_valid,
    input  logic [AW-1:0]  mem_rsp_data,
    output logic           done,
    output logic [AW-1:0]  ea,
    output logic           no_mem,
    output logic           wb_en,
    output logic [AW-1:0]  wb_val
);
    logic [AW-1:0] c_ea;
    logic          c_nomem;
    logic          c_wb_en;
    logic [AW-1:0] c_wb_val;
    logic          c_ind;

    ea_calc #(.AW(AW), .DW(DW), .SZW(SZW)) u_calc (
        .mode      (cmd_mode),
        .base      (cmd_base),
        .index     (cmd_index),
        .disp      (cmd_disp),
        .size_code (cmd_size),
        .ea        (c_ea),
        .nomem     (c_nomem),
        .wb_en     (c_wb_en),
        .wb_val    (c_wb_val),
        .indirect  (c_ind)
    );

    ea_ctrl #(.AW(AW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .calc_ea       (c_ea),
        .calc_nomem    (c_nomem),
        .calc_wb_en    (c_wb_en),
        .calc_wb_val   (c_wb_val),
        .calc_indirect (c_ind),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .ea            (ea),
        .no_mem        (no_mem),
        .wb_en         (wb_en),
        .wb_val        (wb_val)
    );

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready); // R10
    AST_DIRECT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_mode != AM_MIND) |=> !mem_req_valid); // R9

endmodule

// File: tb/tb_ea_gen.sv
`timescale 1ns/1ps
module tb_ea_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [3:0]  cmd_mode = '0;
    logic [31:0] cmd_base = '0;
    logic [31:0] cmd_index = '0;
    logic [15:0] cmd_disp = '0;
    logic [1:0]  cmd_size = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [31:0] ea;
    logic        no_mem;
    logic        wb_en;
    logic [31:0] wb_val;

    always #4 clk = ~clk;

    ea_gen dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_mode(cmd_mode), .cmd_base(cmd_base), .cmd_index(cmd_index),
        .cmd_disp(cmd_disp), .cmd_size(cmd_size),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .ea(ea), .no_mem(no_mem), .wb_en(wb_en), .wb_val(wb_val)
    );

    typedef struct {
        logic [31:0] ea;
        logic        nomem;
        logic        wben;
        logic [31:0] wbv;
        int          due;
        string       tag;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int total = 0;
    int bad = 0;
    int nreq = 0;
    int exp_nreq = 0;
    int stall_cfg = 0;
    int lat_cfg = 0;
    int wcnt = 0;
    int rcnt = 0;
    bit pend = 1'b0;
    logic [31:0] paddr = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_0F0F;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // driver: computes expectation from the requirements, pushes it, drives command
    task automatic send(input logic [3:0] m, input logic [31:0] b, input logic [31:0] x,
                        input logic [15:0] d, input logic [1:0] sz, input string tag);
        exp_t e;
        logic [31:0] dsx;
        logic [31:0] stp;
        dsx = {{16{d[15]}}, d};
        stp = 32'd1 << sz;
        e.ea = '0; e.nomem = 1'b0; e.wben = 1'b0; e.wbv = '0; e.tag = tag;
        case (m)
            4'd2: e.ea = b + dsx;
            4'd3: e.ea = b;
            4'd4: e.ea = b + x;
            4'd5: e.ea = {16'h0, d};
            4'd6: e.ea = memf(b);
            4'd7: begin e.ea = b; e.wben = 1'b1; e.wbv = b + stp; end
            4'd8: begin e.ea = b - stp; e.wben = 1'b1; e.wbv = b - stp; end
            4'd9: e.ea = dsx + b + (x * stp);
            default: e.nomem = 1'b1;
        endcase
        if (m == 4'd6) exp_nreq++;
        cmd_mode = m; cmd_base = b; cmd_index = x; cmd_disp = d; cmd_size = sz;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        e.due = (m == 4'd6) ? -1 : cyc + 1;
        q.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                check(1'b0, "R10", "done with no command pending", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(no_mem == e.nomem, e.tag, "no_mem", {31'd0, no_mem}, {31'd0, e.nomem});
                if (!e.nomem) check(ea == e.ea, e.tag, "ea", ea, e.ea);
                check(wb_en == e.wben, e.tag, "wb_en", {31'd0, wb_en}, {31'd0, e.wben});
                if (e.wben) check(wb_val == e.wbv, e.tag, "wb_val", wb_val, e.wbv);
                if (e.due >= 0)
                    check(cyc == e.due, "R10", "done cycle", cyc, e.due);
            end
        end
    end

    // memory model with configurable stall and response latency
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (rcnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = memf(paddr);
                pend = 1'b0;
            end else begin
                rcnt--;
            end
        end
        mem_req_ready = 1'b0;
        if (rst_n && mem_req_valid) begin
            if (wcnt >= stall_cfg) begin
                mem_req_ready = 1'b1;
                paddr = mem_req_addr;
                pend  = 1'b1;
                rcnt  = lat_cfg;
                wcnt  = 0;
                nreq++;
            end else begin
                wcnt++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R10", "done in reset", {31'd0, done}, 32'd0);
        check(mem_req_valid == 1'b0, "R10", "req in reset", {31'd0, mem_req_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R10", "ready after reset", {31'd0, cmd_ready}, 32'd1);

        send(4'd0, 32'h1234_5678, 32'h0, 16'h0, 2'd0, "R9_reg");
        send(4'd1, 32'h0, 32'h0, 16'h0042, 2'd2, "R9_imm");
        send(4'd12, 32'hDEAD_BEEF, 32'h0, 16'h0, 2'd0, "R9_undef");
        send(4'd2, 32'h0000_1000, 32'h0, 16'h0100, 2'd2, "R1_pos");
        send(4'd2, 32'h0000_1000, 32'h0, 16'hFFF0, 2'd2, "R1_neg");
        send(4'd2, 32'hFFFF_FFF0, 32'h0, 16'h0020, 2'd0, "R1_wrap");
        send(4'd3, 32'hCAFE_0004, 32'h55, 16'h7777, 2'd1, "R2_rind");
        send(4'd4, 32'h0010_0000, 32'h0000_0123, 16'h0, 2'd3, "R2_index");
        send(4'd5, 32'hFFFF_FFFF, 32'h0, 16'h8001, 2'd0, "R3_abs");
        for (int s = 0; s < 4; s++) begin
            send(4'd7, 32'h0000_2000 + s, 32'h0, 16'h0, 2'(s), "R5_R8_post");
            send(4'd8, 32'h0000_3000, 32'h0, 16'h0, 2'(s), "R6_R8_pre");
            send(4'd9, 32'h0000_4000, 32'h0000_0011, 16'hFFFC, 2'(s), "R7_R8_scaled");
        end
        send(4'd8, 32'h0000_0002, 32'h0, 16'h0, 2'd2, "R6_wrap");
        send(4'd9, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0004, 2'd3, "R7_negidx");

        stall_cfg = 0; lat_cfg = 0;
        send(4'd6, 32'h0000_5000, 32'h0, 16'h0, 2'd2, "R4_fast");
        stall_cfg = 3; lat_cfg = 5;
        send(4'd6, 32'hABCD_0010, 32'h0, 16'h0, 2'd2, "R4_slow");
        stall_cfg = 0; lat_cfg = 7;
        send(4'd6, 32'h7777_8888, 32'h0, 16'h0, 2'd0, "R4_latency");
        stall_cfg = 6; lat_cfg = 0;
        send(4'd6, 32'h0101_0202, 32'h0, 16'h0, 2'd0, "R4_stall");
        send(4'd2, 32'h0000_0100, 32'h0, 16'h0001, 2'd0, "R1_after_ind");

        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(nreq == exp_nreq, "R9", "memory read count", nreq, exp_nreq);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule